// File: doc/BRIEF.md
# Packed Integer Multiply Unit

This block multiplies two packed integer registers lane by lane. The register is 128 bits wide. A width select picks either the full 128-bit register or only its low 64 bits. A 3-bit opcode picks how the products are selected. The unit can keep the low or the high half of each 16x16 product, with a signed or an unsigned high half. It can form full 64-bit products from the even 32-bit words. It can also sum the signed products of neighbouring 16-bit lanes into 32-bit lanes.

An operation is offered with a valid/ready handshake. The unit accepts one operation at a time. It registers the operands and computes all lane products in one shared datapath. It then presents the result with an output valid until the consumer takes it. A new operation is accepted only after the previous result has left. The opcode and width are captured when the operation is accepted, so they need not be held afterwards.

Top module: `pmul_unit`

## Requirements
- R1: `inReady` is high only while the unit is empty. An operation is accepted at a rising edge where `inValid` and `inReady` are both high. `outValid` rises at the second rising edge after the accepting edge. While `outValid` is high and `outReady` is low, `result` and `outValid` hold, and `inReady` stays low. The result leaves at an edge where `outValid` and `outReady` are both high, and `inReady` then returns high.
- R2: Opcode 0 (low product): for each 16-bit lane i, result[16i+15:16i] holds bits 15:0 of a_i*b_i. This value is the same whether the lanes are read as signed or unsigned.
- R3: Opcode 1 (unsigned high product): each 16-bit lane holds bits 31:16 of the product of the two lanes, each zero-extended to 32 bits. For example, 0xFFFF and 0xFFFF give 0xFFFE.
- R4: Opcode 2 (signed high product): each 16-bit lane holds bits 31:16 of the product of the two lanes, each sign-extended to 32 bits. For example, 0x8000 and 0x8000 give 0x4000, and 0x7FFF and 0x8000 give 0xC000.
- R5: Opcode 3 (even widening product): each 64-bit lane k holds the 64-bit unsigned product of bits 64k+31:64k of A and of B. The upper 32-bit word of each 64-bit lane of the inputs is ignored.
- R6: Opcode 4 (pairwise multiply-add): each 32-bit lane j holds the sum, taken modulo 2^32, of the signed products of 16-bit lanes 2j and 2j+1. With all four inputs at 0x8000, the lane is 0x80000000.
- R7: With `wideSel` low (64-bit mode), only bits 63:0 of A and B affect the result, and result[127:64] is zero. In this mode opcode 3 yields a single 64-bit lane. With `wideSel` high (128-bit mode), all lanes are computed.
- R8: Opcodes 5, 6 and 7 produce an all-zero result and still follow the handshake of R1.
- R9: After reset, `inReady` is 1, `outValid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An operation is offered |
| inReady | output | 1 | The unit can accept an operation |
| opA | input | 128 | Packed operand A |
| opB | input | 128 | Packed operand B |
| wideSel | input | 1 | 1 selects 128-bit mode, 0 selects 64-bit mode |
| opSel | input | 3 | Opcode: 0 low, 1 unsigned high, 2 signed high, 3 even widening, 4 pairwise multiply-add |
| outValid | output | 1 | `result` holds a finished operation |
| outReady | input | 1 | The consumer takes the result |
| result | output | 128 | Packed result |

## Verification
A wrong product selection or sign extension in one lane shows up in that lane's bits of `result`. It appears in the same beat that `outValid` first rises, two edges after acceptance. Sign-extension faults are exposed by the extreme lane values 0x8000 and 0x7FFF. Wrap-around faults in the pairwise sum are exposed by the all-0x8000 case. A control state that is out of step shows up at once as wrong `inReady` or `outValid` levels, or as a result that changes while the consumer stalls. Every opcode is run in both widths, and 64-bit mode is run with random upper operand bits, so that any leak of upper bits shows up in the first result.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  typedef enum logic [2:0] {
    OP_MUL_LO   = 3'd0,
    OP_MUL_HI_U = 3'd1,
    OP_MUL_HI_S = 3'd2,
    OP_WIDEN    = 3'd3,
    OP_MADD     = 3'd4
  } pmul_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_DONE = 2'd2
  } pmul_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOps;
    logic loadRes;
  } pmul_strobe_t;

endpackage

// File: rtl/pmul_ctrl.sv
module pmul_ctrl
  import pmul_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  output logic         outValid,
  input  logic         outReady,
  output pmul_strobe_t strobe
);

  pmul_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (inValid) stateNext = ST_CALC;
      ST_CALC: stateNext = ST_DONE;
      ST_DONE: if (outReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign inReady        = (state == ST_IDLE);
  assign outValid       = (state == ST_DONE);
  assign strobe.loadOps = inValid && inReady;
  assign strobe.loadRes = (state == ST_CALC);

  AST_IN_OUT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid)); // R1
  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !inReady && !outValid); // R1
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid); // R1
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady |=> inReady); // R1

endmodule

// File: rtl/pmul_dp.sv
module pmul_dp
  import pmul_pkg::*;
#(
  parameter int REG_W  = 128,
  parameter int LANE_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  pmul_strobe_t       strobe,
  input  logic [REG_W-1:0]   opA,
  input  logic [REG_W-1:0]   opB,
  input  logic               wideSel,
  input  logic [2:0]         opSel,
  output logic [REG_W-1:0]   result
);

  localparam int HALF_W    = REG_W / 2;
  localparam int PROD_W    = 2 * LANE_W;
  localparam int NUM_LANES = REG_W / LANE_W;
  localparam int NUM_PAIRS = NUM_LANES / 2;
  localparam int WORD_W    = 32;
  localparam int QUAD_W    = 64;
  localparam int NUM_QUADS = REG_W / QUAD_W;

  logic [REG_W-1:0] aQ, bQ;
  logic             wideQ;
  logic [2:0]       opQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ    <= '0;
      bQ    <= '0;
      wideQ <= 1'b0;
      opQ   <= 3'd0;
    end else if (strobe.loadOps) begin
      aQ    <= wideSel ? opA : {{HALF_W{1'b0}}, opA[HALF_W-1:0]};
      bQ    <= wideSel ? opB : {{HALF_W{1'b0}}, opB[HALF_W-1:0]};
      wideQ <= wideSel;
      opQ   <= opSel;
    end
  end

  logic signedMode;
  assign signedMode = (opQ == OP_MUL_HI_S) || (opQ == OP_MADD);

  logic [PROD_W-1:0] laneProd [NUM_LANES];
  logic [REG_W-1:0]  resLo, resHi, resMadd, resWide;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic signed [PROD_W-1:0] xExt, yExt;
    logic [LANE_W-1:0] xLane, yLane;
    assign xLane = aQ[i*LANE_W +: LANE_W];
    assign yLane = bQ[i*LANE_W +: LANE_W];
    assign xExt = $signed({{LANE_W{signedMode & xLane[LANE_W-1]}}, xLane});
    assign yExt = $signed({{LANE_W{signedMode & yLane[LANE_W-1]}}, yLane});
    assign laneProd[i] = xExt * yExt;
    assign resLo[i*LANE_W +: LANE_W] = laneProd[i][LANE_W-1:0];
    assign resHi[i*LANE_W +: LANE_W] = laneProd[i][PROD_W-1:LANE_W];
  end

  for (genvar j = 0; j < NUM_PAIRS; j++) begin : g_pair
    assign resMadd[j*PROD_W +: PROD_W] = laneProd[2*j] + laneProd[2*j+1];
  end

  for (genvar k = 0; k < NUM_QUADS; k++) begin : g_quad
    logic [QUAD_W-1:0] aExt, bExt;
    assign aExt = {{(QUAD_W-WORD_W){1'b0}}, aQ[k*QUAD_W +: WORD_W]};
    assign bExt = {{(QUAD_W-WORD_W){1'b0}}, bQ[k*QUAD_W +: WORD_W]};
    assign resWide[k*QUAD_W +: QUAD_W] = aExt * bExt;
  end

  logic [REG_W-1:0] resSel, resNext;

  always_comb begin
    case (opQ)
      OP_MUL_LO:   resSel = resLo;
      OP_MUL_HI_U: resSel = resHi;
      OP_MUL_HI_S: resSel = resHi;
      OP_WIDEN:    resSel = resWide;
      OP_MADD:     resSel = resMadd;
      default:     resSel = '0;
    endcase
    resNext = wideQ ? resSel : {{HALF_W{1'b0}}, resSel[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               result <= '0;
    else if (strobe.loadRes) result <= resNext;
  end

  AST_RES_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadRes |=> $stable(result)); // R1
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRes && !wideQ |=> result[REG_W-1:HALF_W] == '0); // R7
  AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRes && (opQ > 3'd4) |=> result == '0); // R8
  AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOps |-> !strobe.loadRes); // R1

endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
#(
  parameter int REG_W  = 128,
  parameter int LANE_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [REG_W-1:0] opA,
  input  logic [REG_W-1:0] opB,
  input  logic             wideSel,
  input  logic [2:0]       opSel,
  output logic             outValid,
  input  logic             outReady,
  output logic [REG_W-1:0] result
);

  pmul_strobe_t strobe;

  pmul_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  pmul_dp #(.REG_W(REG_W), .LANE_W(LANE_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .wideSel (wideSel),
    .opSel   (opSel),
    .result  (result)
  );

endmodule

// File: tb/pmul_unit_tb.sv
module pmul_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] opA = '0, opB = '0;
  logic         wideSel = 1'b0;
  logic [2:0]   opSel = 3'd0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [127:0] result;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmul_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opA(opA), .opB(opB), .wideSel(wideSel), .opSel(opSel),
    .outValid(outValid), .outReady(outReady), .result(result)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [2:0] op, input logic w,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      logic signed [15:0] xs = a[16*i +: 16];
      logic signed [15:0] ys = b[16*i +: 16];
      logic signed [31:0] ps = 32'(xs) * 32'(ys);
      logic [31:0] pu = {16'b0, a[16*i +: 16]} * {16'b0, b[16*i +: 16]};
      case (op)
        3'd0: r[16*i +: 16] = pu[15:0];
        3'd1: r[16*i +: 16] = pu[31:16];
        3'd2: r[16*i +: 16] = ps[31:16];
        default: ;
      endcase
    end
    if (op == 3'd4)
      for (int j = 0; j < 4; j++) begin
        logic signed [15:0] x0 = a[32*j +: 16];
        logic signed [15:0] y0 = b[32*j +: 16];
        logic signed [15:0] x1 = a[32*j+16 +: 16];
        logic signed [15:0] y1 = b[32*j+16 +: 16];
        r[32*j +: 32] = 32'(32'(x0) * 32'(y0)) + 32'(32'(x1) * 32'(y1));
      end
    if (op == 3'd3)
      for (int k = 0; k < 2; k++)
        r[64*k +: 64] = {32'b0, a[64*k +: 32]} * {32'b0, b[64*k +: 32]};
    if (!w) r[127:64] = '0;
    return r;
  endfunction

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic runOp(input logic [2:0] op, input logic w,
                       input logic [127:0] a, input logic [127:0] b, input int hold);
    logic [127:0] exp = model(op, w, a, b);
    @(negedge clk);
    check(inReady == 1'b1, "R1 ready before accept", 128'(inReady), 128'd1);
    inValid = 1'b1; opSel = op; wideSel = w; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0; opSel = 3'($urandom()); wideSel = ~w; opA = '1; opB = '1;
    check(!outValid && !inReady, "R1 busy after accept",
          {outValid, inReady}, 128'd0);
    @(negedge clk);
    check(outValid == 1'b1, "R1 valid at second edge", 128'(outValid), 128'd1);
    check(result == exp, opTag(op), result, exp);
    if (!w) check(result[127:64] == '0, "R7 upper zero", result, exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(outValid && !inReady && result == exp, "R1 hold while stalled",
            result, exp);
    end
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(!outValid && inReady, "R1 release", {outValid, inReady}, 128'b01);
  endtask

  function automatic logic [127:0] rnd128(input bit extremes);
    logic [127:0] v = {$urandom(), $urandom(), $urandom(), $urandom()};
    if (extremes)
      for (int i = 0; i < 8; i++) begin
        int c = $urandom_range(0, 3);
        if (c == 0) v[16*i +: 16] = 16'h8000;
        else if (c == 1) v[16*i +: 16] = 16'h7FFF;
      end
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(inReady == 1'b1 && outValid == 1'b0 && result == '0, "R9 reset",
          {inReady, outValid, result[125:0]}, {2'b10, 126'd0});
    rstN = 1'b1;

    // directed corners, both widths
    for (int w = 0; w < 2; w++) begin
      runOp(3'd4, w[0], {8{16'h8000}}, {8{16'h8000}}, 0);      // R6 wrap 0x80000000
      runOp(3'd2, w[0], {8{16'h8000}}, {8{16'h8000}}, 1);      // R4 0x4000
      runOp(3'd2, w[0], {8{16'h7FFF}}, {8{16'h8000}}, 0);      // R4 0xC000
      runOp(3'd1, w[0], {8{16'hFFFF}}, {8{16'hFFFF}}, 2);      // R3 0xFFFE
      runOp(3'd0, w[0], {8{16'h7FFF}}, {8{16'h8000}}, 0);      // R2
      runOp(3'd3, w[0], {4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, 0); // R5
      runOp(3'd3, w[0], {32'h1, 32'h2, 32'hDEAD, 32'h3},
                        {32'h5, 32'h7, 32'hBEEF, 32'h4}, 0);    // R5 odd words ignored
      runOp(3'd6, w[0], '1, '1, 1);                            // R8
      runOp(3'd7, w[0], '1, '1, 0);                            // R8
    end
    // R7: 64-bit mode with garbage in upper operand halves
    runOp(3'd4, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, {4{16'h1234}}},
                      {64'h8000_8000_8000_8000, {4{16'h0002}}}, 0);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [2:0] op = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7))
                                                    : 3'($urandom_range(0, 4));
      runOp(op, 1'($urandom()), rnd128(n % 2 == 0), rnd128(n % 3 == 0),
            $urandom_range(0, 2));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule